// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the system reset, as an active-high and an active-low output that are always complements of each other. Three conditions can cause a reset. The first is a power-good flag from an external supply comparator. The second is an active-low pushbutton. The third is a one-cycle expiry pulse from a separate watchdog counter. Every condition is held for as long as it is present. Once it clears, the reset is stretched for a minimum time that is counted in one-millisecond ticks. A tick-enable input supplies those ticks.

The pushbutton is asynchronous. It passes through a synchroniser and then a debouncer before it counts as a cause. For a pushbutton reset, the minimum-width interval starts only when the debounced button is released. One stretch timer serves all three causes, and any new cause reloads it. The block also passes a supply-tolerance selection straight through to the comparator. That selection chooses between the 5 % (4.75 V) threshold and the 10 % (4.5 V) threshold.

Reset is controlled by a three-state machine:

- **S_CAUSE**: a cause is present and reset is held.
- **S_STRETCH**: the minimum-width countdown is running and reset is still held.
- **S_RUN**: reset is released.

The machine has four transitions:

- **cause_seen**: any state goes to S_CAUSE when a cause is present.
- **cause_gone**: S_CAUSE goes to S_STRETCH and the counter is loaded.
- **stretch_done**: S_STRETCH goes to S_RUN on the tick that ends the countdown.
- **power-on clear**: the asynchronous clear puts the machine in S_STRETCH with the counter loaded.

The power-good input is expected to be synchronous to the clock.

Top module: `sup_reset_gen`

## Requirements
- R1: `sys_rst` and `sys_rst_n` are complements in every cycle.
- R2: While `pwr_good` is low, `sys_rst` is 1 from the next cycle onward.
- R3: After `pwr_good` returns high, `sys_rst` stays 1 for at least `STRETCH_MS` ticks and goes to 0 by the tick after that.
- R4: A low level on `pb_n` takes effect only after the synchronised level has differed from the accepted level for `DEB_MS` ticks. A low pulse shorter than that leaves `sys_rst` at 0.
- R5: While the debounced button is held, `sys_rst` is 1. The `STRETCH_MS`-tick interval starts when the debounced release is accepted.
- R6: A one-cycle high pulse on `wdt_expire` makes `sys_rst` 1 in the next cycle and holds it for at least `STRETCH_MS` ticks.
- R7: A cause that arrives while the stretch is running restarts the full `STRETCH_MS`-tick interval.
- R8: `tol_sel_out` equals `tol_sel_in` at all times. Value 0 selects the 5 % threshold and value 1 selects the 10 % threshold.
- R9: The asynchronous clear leaves `sys_rst` at 1. With no cause present, reset releases after `STRETCH_MS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| tick_1ms | input | 1 | One-cycle millisecond tick enable |
| pwr_good | input | 1 | Supply comparator result, 1 when the supply is within tolerance |
| pb_n | input | 1 | Asynchronous active-low pushbutton |
| wdt_expire | input | 1 | One-cycle watchdog expiry pulse |
| tol_sel_in | input | 1 | Tolerance select: 0 for 5 %, 1 for 10 % |
| tol_sel_out | output | 1 | Tolerance select forwarded to the comparator |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench sends a pushbutton glitch shorter than the debounce window. A debouncer that takes the first low sample would emit a spurious reset. It checks that reset is still high well after a button release. A design that timed from the press, or that skipped the debounce on release, would let reset drop early. A second watchdog pulse halfway through a stretch must push the release out by a full interval. A timer that kept counting down would release too soon. Power-on and power-fail release times are sampled on both sides of the interval, so a stretch that is too short or one that never ends would both be caught.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        S_CAUSE   = 2'd0,
        S_STRETCH = 2'd1,
        S_RUN     = 2'd2
    } sup_state_t;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int DEB_MS  = 10,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic level_in,
    output logic level_out
);
    localparam int CW = $clog2(DEB_MS + 1);

    logic          accepted;
    logic [CW-1:0] stable_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accepted   <= RST_VAL;
            stable_cnt <= '0;
        end else if (level_in == accepted) begin
            stable_cnt <= '0;
        end else if (tick) begin
            if (stable_cnt == CW'(DEB_MS - 1)) begin
                accepted   <= level_in;
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end

    assign level_out = accepted;
endmodule

// File: rtl/sup_stretch_fsm.sv
module sup_stretch_fsm
    import sup_pkg::*;
#(
    parameter int STRETCH_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic rst_active
);
    localparam int CW = $clog2(STRETCH_MS + 1);

    sup_state_t    state, state_nx;
    logic [CW-1:0] remain;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CAUSE: begin
                if (!cause) state_nx = S_STRETCH;
            end
            S_STRETCH: begin
                if (cause)                               state_nx = S_CAUSE;
                else if (tick && remain == CW'(1))       state_nx = S_RUN;
            end
            S_RUN: begin
                if (cause) state_nx = S_CAUSE;
            end
            default: state_nx = S_CAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_STRETCH;
            remain <= CW'(STRETCH_MS);
        end else begin
            state <= state_nx;
            if (state_nx == S_CAUSE)
                remain <= CW'(STRETCH_MS);
            else if (state == S_STRETCH && tick && remain != '0)
                remain <= remain - 1'b1;
        end
    end

    always_comb begin
        rst_active = (state != S_RUN);
    end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int STRETCH_MS  = 250,
    parameter int DEB_MS      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic pwr_good,
    input  logic pb_n,
    input  logic wdt_expire,
    input  logic tol_sel_in,
    output logic tol_sel_out,
    output logic sys_rst,
    output logic sys_rst_n
);
    logic pb_sync;
    logic pb_level;
    logic pb_held;
    logic cause;
    logic rst_active;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pb_n),
        .q_sync  (pb_sync)
    );

    sup_debounce #(.DEB_MS(DEB_MS), .RST_VAL(1'b1)) i_pb_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1ms),
        .level_in  (pb_sync),
        .level_out (pb_level)
    );

    assign pb_held = ~pb_level;
    assign cause   = ~pwr_good | pb_held | wdt_expire;

    sup_stretch_fsm #(.STRETCH_MS(STRETCH_MS)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1ms),
        .cause      (cause),
        .rst_active (rst_active)
    );

    assign sys_rst     = rst_active;
    assign sys_rst_n   = ~rst_active;
    assign tol_sel_out = tol_sel_in;
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
    parameter int STRETCH_MS = 250
) (
    input logic clk,
    input logic rst_n,
    input logic tick_1ms,
    input logic pwr_good,
    input logic wdt_expire,
    input logic pb_held,
    input logic tol_sel_in,
    input logic tol_sel_out,
    input logic sys_rst,
    input logic sys_rst_n
);
    logic [15:0] quiet_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            quiet_ticks <= '0;
        else if (!pwr_good || wdt_expire || pb_held)
            quiet_ticks <= '0;
        else if (tick_1ms && quiet_ticks != 16'hFFFF)
            quiet_ticks <= quiet_ticks + 16'd1;
    end

    a_r1_complement: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst == ~sys_rst_n);

    a_r2_power_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> sys_rst);

    a_r5_button_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pb_held |=> sys_rst);

    a_r6_watchdog_assert: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expire |=> sys_rst);

    a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (quiet_ticks >= 16'(STRETCH_MS)));

    a_r8_tol_pass: assert property (@(posedge clk) disable iff (!rst_n)
        tol_sel_out == tol_sel_in);
endmodule

bind sup_reset_gen sup_reset_gen_chk #(.STRETCH_MS(STRETCH_MS)) i_sup_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .pwr_good    (pwr_good),
    .wdt_expire  (wdt_expire),
    .pb_held     (pb_held),
    .tol_sel_in  (tol_sel_in),
    .tol_sel_out (tol_sel_out),
    .sys_rst     (sys_rst),
    .sys_rst_n   (sys_rst_n)
);

// File: tb/test_sup_reset_gen.sv
`timescale 1ns/1ps
module test_sup_reset_gen;
    localparam int STRETCH_MS = 5;
    localparam int DEB_MS     = 3;
    localparam int TICK_DIV   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic pwr_good = 1'b1;
    logic pb_n = 1'b1;
    logic wdt_expire = 1'b0;
    logic tol_sel_in = 1'b0;
    logic tol_sel_out, sys_rst, sys_rst_n;

    int unsigned cyc = 0;
    int unsigned tdiv = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int unsigned at;
        logic        exp;
        string       req;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    sup_reset_gen #(.STRETCH_MS(STRETCH_MS), .DEB_MS(DEB_MS), .SYNC_STAGES(2)) i_sup_reset_gen (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_good(pwr_good),
        .pb_n(pb_n), .wdt_expire(wdt_expire), .tol_sel_in(tol_sel_in),
        .tol_sel_out(tol_sel_out), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_1ms <= (tdiv == TICK_DIV - 1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (sys_rst !== it.exp) begin
                errors++;
                $display("FAIL %s: sys_rst=%b expected %b at cycle %0d", it.req, sys_rst, it.exp, cyc);
            end
            checks++;
            if (sys_rst_n !== ~it.exp) begin
                errors++;
                $display("FAIL R1: sys_rst_n=%b expected %b at cycle %0d", sys_rst_n, ~it.exp, cyc);
            end
        end
    end

    task automatic expect_at(input int unsigned offs, input logic e, input string req);
        exp_t it;
        it.at = cyc + offs; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic check_tol(input logic v);
        tol_sel_in = v;
        #1;
        checks++;
        if (tol_sel_out !== v) begin
            errors++;
            $display("FAIL R8: tol_sel_out=%b expected %b", tol_sel_out, v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (sys_rst !== 1'b1 || sys_rst_n !== 1'b0) begin
            errors++;
            $display("FAIL R9: in clear sys_rst=%b sys_rst_n=%b expected 1/0", sys_rst, sys_rst_n);
        end
        rst_n = 1'b1;
        // R9 power-on release after the stretch
        expect_at(2, 1'b1, "R9");
        expect_at(30, 1'b1, "R9");
        expect_at(75, 1'b0, "R9");
        drain();

        // R2 / R3 power fail and recovery
        @(negedge clk); pwr_good = 1'b0;
        expect_at(2, 1'b1, "R2");
        expect_at(100, 1'b1, "R2");
        expect_at(199, 1'b1, "R2");
        repeat (200) @(negedge clk);
        pwr_good = 1'b1;
        expect_at(35, 1'b1, "R3");
        expect_at(75, 1'b0, "R3");
        drain();

        // R4 short glitch ignored
        @(negedge clk); pb_n = 1'b0;
        for (int k = 1; k <= 6; k++) expect_at(10 * k, 1'b0, "R4");
        repeat (15) @(negedge clk);
        pb_n = 1'b1;
        drain();

        // R4 / R5 held button, stretch from release
        @(negedge clk); pb_n = 1'b0;
        expect_at(45, 1'b1, "R4");
        expect_at(149, 1'b1, "R5");
        repeat (150) @(negedge clk);
        pb_n = 1'b1;
        expect_at(55, 1'b1, "R5");
        expect_at(130, 1'b0, "R5");
        drain();

        // R6 watchdog pulse
        @(negedge clk); wdt_expire = 1'b1;
        expect_at(1, 1'b1, "R6");
        expect_at(35, 1'b1, "R6");
        expect_at(80, 1'b0, "R6");
        @(negedge clk); wdt_expire = 1'b0;
        drain();

        // R7 retrigger mid-stretch
        @(negedge clk); wdt_expire = 1'b1;
        @(negedge clk); wdt_expire = 1'b0;
        repeat (29) @(negedge clk);
        wdt_expire = 1'b1;
        expect_at(35, 1'b1, "R7");
        expect_at(80, 1'b0, "R7");
        @(negedge clk); wdt_expire = 1'b0;
        drain();

        // R8 tolerance select
        check_tol(1'b1);
        check_tol(1'b0);
        check_tol(1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule